// File: doc/BRIEF.md
# Bus Target with Disconnect-With-Data Control

This block is a simplified bus target for a multiplexed address/data bus that uses the usual active-low FRAME#, IRDY#, TRDY#, STOP# and DEVSEL# handshake. It samples the address phase, claims memory reads and memory writes that fall inside a small word-aligned window, and completes data phases against a local bank of 32-bit words. The window is split into two parts. The low part holds control words, and a burst into it always ends after one word. The upper part accepts bursts until the word at the top of the window.

When a burst has to end, the target drives STOP#, TRDY# and DEVSEL# low together, so one last word still moves. That state holds through any number of initiator wait states, until IRDY# completes the transfer. On the next clock the target releases all three signals and drives them high for one cycle. It then stops driving them and waits for an idle bus before it decodes again. Parity, configuration cycles, retry, abort and arbitration are left to other blocks.

Top module: `pci_dsc_target`

## Requirements
- R1: After reset, trdy_n, stop_n and devsel_n are 1, ctl_oe and ad_oe are 0, and every word of the bank reads back as zero.
- R2: The target claims only when FRAME# is sampled low in the idle state, the address is word aligned inside the window (word index = ad_in[4:2] at the default size), and cbe_n is 4'b0110 (memory read) or 4'b0111 (memory write). A claim uses medium decode: devsel_n and trdy_n go low on the second clock edge after the address edge, never before. Any other address or command leaves devsel_n high.
- R3: If FRAME# is already high at the clock edge after the address edge, the access is single-phase. It transfers one word with stop_n held high.
- R4: A burst (FRAME# still low at that edge) that starts at a control word (index below REG_WORDS, words 0 to 3 by default) carries stop_n low together with trdy_n and devsel_n on its first data phase. Exactly one word transfers.
- R5: A burst in the upper part transfers one word per phase with stop_n high. The phase at the top word of the window (index 7 by default) carries stop_n low, so the count of words moved is min(requested, top index − start + 1).
- R6: While trdy_n is low and IRDY# is high, trdy_n, stop_n and devsel_n keep their values.
- R7: On the clock after the final transfer, trdy_n, stop_n and devsel_n are all 1 with ctl_oe still 1. One clock later ctl_oe is 0. ad_oe is 0 after the final transfer.
- R8: After a transaction, or after a transaction the target did not claim, no new decode starts until FRAME# and IRDY# have both been sampled high.
- R9: A write updates only the byte lanes whose cbe_n bit is 0 (bit i controls ad_in[8i+7:8i]). During a read data phase, ad_oe is 1 and ad_out carries the addressed word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_n | input | 1 | FRAME# from the initiator |
| irdy_n | input | 1 | IRDY# from the initiator |
| cbe_n | input | 4 | Command during the address phase, active-low byte enables during data phases |
| ad_in | input | 32 | Address/data as driven by the initiator |
| ad_out | output | 32 | Read data driven toward the bus |
| ad_oe | output | 1 | Enable for ad_out |
| trdy_n | output | 1 | TRDY# from the target |
| stop_n | output | 1 | STOP# from the target |
| devsel_n | output | 1 | DEVSEL# from the target |
| ctl_oe | output | 1 | Enable for trdy_n, stop_n and devsel_n |

## Verification
The assertions assume the initiator follows the bus rules. FRAME# rises only while IRDY# is low, FRAME# goes high on the clock after STOP# ends a transfer, and the bus returns to idle between transactions. Single-phase recognition also assumes that the first data phase has no IRDY# wait states, so that FRAME# already shows the last phase at the claim edge. The bench initiator model keeps to these rules. It adds random IRDY# wait states only to the later phases of a burst and always leaves idle cycles between transactions. The one directed case that breaks bus idle does so on purpose, to show that the target stays off the bus.

// File: rtl/pci_dsc_pkg.sv
package pci_dsc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_CLAIM = 3'd1,
      ST_DATA  = 3'd2,
      ST_TURN  = 3'd3,
      ST_BUSY  = 3'd4
   } tgt_state_e;

   localparam logic [3:0] CMD_MEM_RD = 4'b0110;
   localparam logic [3:0] CMD_MEM_WR = 4'b0111;

endpackage

// File: rtl/pci_dsc_decode.sv
module pci_dsc_decode
   import pci_dsc_pkg::*;
#(
   parameter int          ADDR_W    = 32,
   parameter logic [31:0] BASE_ADDR = 32'h0000_1000,
   parameter int          IDX_W     = 3
)(
   input  logic [ADDR_W-1:0] ad_addr,
   input  logic [3:0]        cmd_n,
   output logic              hit,
   output logic              is_write,
   output logic [IDX_W-1:0]  word_idx
);
   localparam int TAG_LO = IDX_W + 2;

   logic cmd_ok;
   logic range_ok;

   assign cmd_ok   = (cmd_n == CMD_MEM_RD) || (cmd_n == CMD_MEM_WR);
   assign is_write = (cmd_n == CMD_MEM_WR);
   assign word_idx = ad_addr[TAG_LO-1:2];

   generate
      if (ADDR_W > TAG_LO) begin : g_tag
         assign range_ok = (ad_addr[ADDR_W-1:TAG_LO] == BASE_ADDR[ADDR_W-1:TAG_LO]);
      end else begin : g_full
         assign range_ok = 1'b1;
      end
   endgenerate

   assign hit = cmd_ok && range_ok && (ad_addr[1:0] == 2'b00);

endmodule

// File: rtl/pci_dsc_regfile.sv
module pci_dsc_regfile #(
   parameter int DATA_W = 32,
   parameter int WORDS  = 8,
   parameter int IDX_W  = 3
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [IDX_W-1:0]    wr_idx,
   input  logic [DATA_W/8-1:0] wr_be_n,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic [IDX_W-1:0]    rd_idx,
   output logic [DATA_W-1:0]   rd_data
);
   localparam int LANES = DATA_W / 8;

   logic [DATA_W-1:0] bank [WORDS];

   generate
      for (genvar w = 0; w < WORDS; w++) begin : g_word
         logic [DATA_W-1:0] word_q;
         logic              sel;

         assign sel = wr_en && (wr_idx == IDX_W'(w));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               word_q <= '0;
            end else if (sel) begin
               for (int b = 0; b < LANES; b++) begin
                  if (!wr_be_n[b]) word_q[8*b +: 8] <= wr_data[8*b +: 8];
               end
            end
         end

         assign bank[w] = word_q;
      end
   endgenerate

   assign rd_data = bank[rd_idx];

endmodule

// File: rtl/pci_dsc_seq.sv
module pci_dsc_seq
   import pci_dsc_pkg::*;
#(
   parameter int WIN_WORDS = 8,
   parameter int REG_WORDS = 4,
   parameter int IDX_W     = 3
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_n,
   input  logic             irdy_n,
   input  logic             dec_hit,
   input  logic             dec_write,
   input  logic [IDX_W-1:0] dec_idx,
   output logic             trdy_n,
   output logic             stop_n,
   output logic             devsel_n,
   output logic             ctl_oe,
   output logic [IDX_W-1:0] cur_idx,
   output logic             wr_fire,
   output logic             rd_drive
);
   localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(WIN_WORDS - 1);
   localparam logic [IDX_W:0]   REG_LIM = (IDX_W+1)'(REG_WORDS);

   tgt_state_e       state_q;
   logic [IDX_W-1:0] idx_q;
   logic [IDX_W-1:0] idx_nxt;
   logic             wr_q;
   logic             trdy_q, stop_q, devsel_q, oe_q;
   logic             xfer;

   // a phase at this word ends a burst: control word, or top of window
   function automatic logic ends_burst(input logic [IDX_W-1:0] i);
      return ({1'b0, i} < REG_LIM) || (i == TOP_IDX);
   endfunction

   assign idx_nxt = idx_q + IDX_W'(1);
   assign xfer    = (state_q == ST_DATA) && !irdy_n && !trdy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         idx_q    <= '0;
         wr_q     <= 1'b0;
         trdy_q   <= 1'b1;
         stop_q   <= 1'b1;
         devsel_q <= 1'b1;
         oe_q     <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (!frame_n) begin
                  idx_q   <= dec_idx;
                  wr_q    <= dec_write;
                  state_q <= dec_hit ? ST_CLAIM : ST_BUSY;
               end
            end
            ST_CLAIM: begin
               state_q  <= ST_DATA;
               devsel_q <= 1'b0;
               trdy_q   <= 1'b0;
               oe_q     <= 1'b1;
               stop_q   <= ~(~frame_n & ends_burst(idx_q));
            end
            ST_DATA: begin
               if (xfer) begin
                  if (!stop_q || frame_n) begin
                     state_q  <= ST_TURN;
                     trdy_q   <= 1'b1;
                     stop_q   <= 1'b1;
                     devsel_q <= 1'b1;
                  end else begin
                     idx_q  <= idx_nxt;
                     stop_q <= ~ends_burst(idx_nxt);
                  end
               end
            end
            ST_TURN: begin
               oe_q    <= 1'b0;
               state_q <= ST_BUSY;
            end
            ST_BUSY: begin
               if (frame_n && irdy_n) state_q <= ST_IDLE;
            end
            default: state_q <= ST_BUSY;
         endcase
      end
   end

   assign trdy_n   = trdy_q;
   assign stop_n   = stop_q;
   assign devsel_n = devsel_q;
   assign ctl_oe   = oe_q;
   assign cur_idx  = idx_q;
   assign wr_fire  = xfer && wr_q;
   assign rd_drive = (state_q == ST_DATA) && !wr_q;

endmodule

// File: rtl/pci_dsc_target.sv
module pci_dsc_target
   import pci_dsc_pkg::*;
#(
   parameter int          DATA_W    = 32,
   parameter logic [31:0] BASE_ADDR = 32'h0000_1000,
   parameter int          WIN_WORDS = 8,
   parameter int          REG_WORDS = 4
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          frame_n,
   input  logic          irdy_n,
   input  logic [3:0]    cbe_n,
   input  logic [31:0]   ad_in,
   output logic [31:0]   ad_out,
   output logic          ad_oe,
   output logic          trdy_n,
   output logic          stop_n,
   output logic          devsel_n,
   output logic          ctl_oe
);
   localparam int IDX_W = (WIN_WORDS > 1) ? $clog2(WIN_WORDS) : 1;
   localparam int LANES = DATA_W / 8;

   generate
      if (DATA_W != 32)
         $error("DATA_W must equal the 32-bit bus width");
      if (WIN_WORDS < 2 || (WIN_WORDS & (WIN_WORDS - 1)) != 0)
         $error("WIN_WORDS must be a power of two, at least 2");
      if (REG_WORDS < 1 || REG_WORDS > WIN_WORDS)
         $error("REG_WORDS must lie in 1..WIN_WORDS");
      if ((BASE_ADDR % (WIN_WORDS * 4)) != 0)
         $error("BASE_ADDR must be aligned to the window size");
   endgenerate

   logic             dec_hit, dec_write;
   logic [IDX_W-1:0] dec_idx, cur_idx;
   logic             wr_fire, rd_drive;
   logic [DATA_W-1:0] rd_data;

   pci_dsc_decode #(
      .ADDR_W    (32),
      .BASE_ADDR (BASE_ADDR),
      .IDX_W     (IDX_W)
   ) u_dec (
      .ad_addr  (ad_in),
      .cmd_n    (cbe_n),
      .hit      (dec_hit),
      .is_write (dec_write),
      .word_idx (dec_idx)
   );

   pci_dsc_seq #(
      .WIN_WORDS (WIN_WORDS),
      .REG_WORDS (REG_WORDS),
      .IDX_W     (IDX_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_n   (frame_n),
      .irdy_n    (irdy_n),
      .dec_hit   (dec_hit),
      .dec_write (dec_write),
      .dec_idx   (dec_idx),
      .trdy_n    (trdy_n),
      .stop_n    (stop_n),
      .devsel_n  (devsel_n),
      .ctl_oe    (ctl_oe),
      .cur_idx   (cur_idx),
      .wr_fire   (wr_fire),
      .rd_drive  (rd_drive)
   );

   pci_dsc_regfile #(
      .DATA_W (DATA_W),
      .WORDS  (WIN_WORDS),
      .IDX_W  (IDX_W)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_fire),
      .wr_idx  (cur_idx),
      .wr_be_n (cbe_n[LANES-1:0]),
      .wr_data (ad_in[DATA_W-1:0]),
      .rd_idx  (cur_idx),
      .rd_data (rd_data)
   );

   assign ad_oe  = rd_drive;
   assign ad_out = rd_drive ? rd_data : '0;

endmodule

// File: rtl/pci_dsc_checker.sv
module pci_dsc_checker (
   input logic clk,
   input logic rst_n,
   input logic frame_n,
   input logic irdy_n,
   input logic trdy_n,
   input logic stop_n,
   input logic devsel_n,
   input logic ctl_oe,
   input logic ad_oe
);
   // R2: a claim shows up two edges after the address was sampled
   a_r2_medium_decode: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(devsel_n) |-> ($past(frame_n, 2) == 1'b0));

   // R4 / R5: a disconnect always carries data with it
   a_r4_disc_with_data: assert property (@(posedge clk) disable iff (!rst_n)
      !stop_n |-> (!trdy_n && !devsel_n));

   // R6: initiator wait states freeze the target response
   a_r6_hold_on_wait: assert property (@(posedge clk) disable iff (!rst_n)
      (!trdy_n && irdy_n) |=> ($stable(trdy_n) && $stable(stop_n) && $stable(devsel_n)));

   // R7: release after the final word, still driven high
   a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
      (!trdy_n && !irdy_n && (!stop_n || frame_n)) |=> (trdy_n && stop_n && devsel_n && ctl_oe));

   // R7: one driven-high cycle, then float
   a_r7_float: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_oe && devsel_n) |=> !ctl_oe);

   // R9: read data is driven only inside a claimed data phase
   a_r9_read_drive: assert property (@(posedge clk) disable iff (!rst_n)
      ad_oe |-> (!devsel_n && !trdy_n && ctl_oe));

endmodule

bind pci_dsc_target pci_dsc_checker u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .frame_n  (frame_n),
   .irdy_n   (irdy_n),
   .trdy_n   (trdy_n),
   .stop_n   (stop_n),
   .devsel_n (devsel_n),
   .ctl_oe   (ctl_oe),
   .ad_oe    (ad_oe)
);

// File: tb/tb_pci_dsc_target.sv
`timescale 1ns/100ps
module tb_pci_dsc_target;
   localparam logic [31:0] BASE = 32'h0000_1000;
   localparam int WIN  = 8;
   localparam int REGS = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_n = 1'b1, irdy_n = 1'b1;
   logic [3:0]  cbe_n = 4'h0;
   logic [31:0] ad_in = '0;
   logic [31:0] ad_out;
   logic        ad_oe, trdy_n, stop_n, devsel_n, ctl_oe;

   int vectors = 0;
   int misses  = 0;
   logic [31:0] mem [WIN];

   always #2.5 clk = ~clk;

   pci_dsc_target #(.BASE_ADDR(BASE), .WIN_WORDS(WIN), .REG_WORDS(REGS)) dut (
      .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
      .cbe_n(cbe_n), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
      .trdy_n(trdy_n), .stop_n(stop_n), .devsel_n(devsel_n), .ctl_oe(ctl_oe)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (!ok) begin
         misses++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // stop expected on phase p of a burst of n words starting at start
   function automatic bit exp_stop(int p, int start, int n);
      int w = start + p;
      if (p == 0) return (n > 1) && ((w < REGS) || (w == WIN - 1));
      return (w == WIN - 1);
   endfunction

   function automatic int exp_count(int start, int n);
      int c = 0;
      for (int p = 0; p < n; p++) begin
         c++;
         if (exp_stop(p, start, n)) break;
      end
      return c;
   endfunction

   task automatic idle(int k);
      repeat (k) @(negedge clk);
   endtask

   task automatic txn(bit wr, int start, int n, int maxwait);
      int p = 0;
      int tmo;
      bit got_stop = 1'b0;
      bit es;
      logic [31:0] d;
      logic [3:0]  m;
      string tag;
      @(negedge clk);
      frame_n = 1'b0; irdy_n = 1'b1;
      cbe_n = wr ? 4'b0111 : 4'b0110;
      ad_in = BASE + 32'(start * 4);
      @(negedge clk);
      chk(devsel_n == 1'b1, "R2 no DEVSEL# one edge after address", 32'(devsel_n), 32'd1);
      forever begin
         es = exp_stop(p, start, n);
         if (p > 0) begin
            int wt = int'($urandom_range(maxwait, 0));
            repeat (wt) begin
               irdy_n = 1'b1;
               @(negedge clk);
               chk(!trdy_n && !devsel_n && (stop_n == !es), "R6 response held in IRDY# wait",
                   {29'd0, trdy_n, stop_n, devsel_n}, {29'd0, 1'b0, !es, 1'b0});
            end
         end
         m = 4'($urandom); d = $urandom;
         irdy_n = 1'b0;
         frame_n = (p == n - 1);
         cbe_n = wr ? m : 4'b0000;
         ad_in = wr ? d : 32'd0;
         tmo = 0;
         while (trdy_n && tmo < 8) begin @(negedge clk); tmo++; end
         if (p == 0)
            chk(tmo == 1 && !devsel_n, "R2 medium decode latency", 32'(tmo), 32'd1);
         else
            chk(tmo == 0, "R5 TRDY# ready for next burst phase", 32'(tmo), 32'd0);
         tag = (n == 1) ? "R3 single phase STOP#" :
               (start < REGS) ? "R4 control word STOP#" : "R5 window end STOP#";
         got_stop = !stop_n;
         chk(got_stop == es, tag, 32'(got_stop), 32'(es));
         if (wr) begin
            for (int b = 0; b < 4; b++)
               if (!m[b]) mem[start + p][8*b +: 8] = d[8*b +: 8];
         end else begin
            chk(ad_oe && ad_out == mem[start + p], "R9 read data on AD", ad_out, mem[start + p]);
         end
         @(negedge clk);
         p++;
         if (got_stop || p == n) break;
      end
      chk(trdy_n && stop_n && devsel_n && ctl_oe && !ad_oe, "R7 release after final word",
          {27'd0, trdy_n, stop_n, devsel_n, ctl_oe, ad_oe}, 32'b11110);
      chk(p == exp_count(start, n), "R4 words moved in transaction", 32'(p), 32'(exp_count(start, n)));
      frame_n = 1'b1; irdy_n = 1'b1; cbe_n = 4'h0; ad_in = '0;
      @(negedge clk);
      chk(!ctl_oe, "R7 float after turnaround", 32'(ctl_oe), 32'd0);
      idle(1);
   endtask

   // address phase the target must ignore
   task automatic foreign(logic [31:0] addr, logic [3:0] cmd, string req);
      bit seen = 1'b0;
      @(negedge clk);
      frame_n = 1'b0; cbe_n = cmd; ad_in = addr;
      @(negedge clk);
      frame_n = 1'b1; irdy_n = 1'b0; cbe_n = 4'h0; ad_in = '0;
      repeat (4) begin @(negedge clk); if (!devsel_n || ctl_oe) seen = 1'b1; end
      chk(!seen, req, 32'(seen), 32'd0);
      irdy_n = 1'b1;
      idle(2);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      misses++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

   initial begin : stim
      bit seen;
      void'($urandom(32'd20240611));
      for (int i = 0; i < WIN; i++) mem[i] = '0;
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);
      chk(trdy_n && stop_n && devsel_n && !ctl_oe && !ad_oe, "R1 reset outputs",
          {27'd0, trdy_n, stop_n, devsel_n, ctl_oe, ad_oe}, 32'b11100);
      txn(1'b0, 5, 1, 0);                       // R1 reset contents read as zero
      for (int w = 0; w < WIN; w++) txn(1'b1, w, 1, 0);   // R3 single writes
      for (int w = 0; w < WIN; w++) txn(1'b0, w, 1, 0);   // R9 single reads
      txn(1'b1, 1, 4, 2);                       // R4 control burst
      txn(1'b0, 0, 3, 2);
      txn(1'b1, 4, 4, 2);                       // R5 runs to window top
      txn(1'b0, 5, 6, 3);                       // R5 cut at top
      txn(1'b1, 7, 2, 1);                       // R5 burst starting at top
      txn(1'b0, 4, 4, 3);
      foreign(BASE + 32'h40, 4'b0110, "R2 out-of-window address ignored");
      foreign(BASE + 32'h10, 4'b0010, "R2 non-memory command ignored");
      foreign(BASE + 32'h12, 4'b0111, "R2 misaligned address ignored");
      // R8: bus not idle, a fresh FRAME# must not be decoded
      @(negedge clk);
      frame_n = 1'b0; cbe_n = 4'b0010; ad_in = BASE;
      @(negedge clk);
      frame_n = 1'b1; irdy_n = 1'b0;
      @(negedge clk);
      frame_n = 1'b0; cbe_n = 4'b0111; ad_in = BASE + 32'h14;
      seen = 1'b0;
      repeat (4) begin @(negedge clk); if (!devsel_n) seen = 1'b1; end
      chk(!seen, "R8 no decode before idle bus", 32'(seen), 32'd0);
      frame_n = 1'b1; irdy_n = 1'b1; cbe_n = 4'h0; ad_in = '0;
      idle(2);
      txn(1'b0, 5, 2, 1);                       // R8 decode resumes after idle
      for (int k = 0; k < 90; k++) begin
         txn(1'($urandom_range(1, 0)), int'($urandom_range(WIN - 1, 0)),
             int'($urandom_range(4, 1)), 2);
      end
      for (int w = 0; w < WIN; w++) txn(1'b0, w, 1, 0);   // R9 final contents
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

endmodule